// File: doc/BRIEF.md
# Next Memory Address and Program Counter Generator

This block holds the 12-bit memory address register and the program counter of a small word-addressed processor whose memory is divided into pages of 128 words. Each clock edge, a sequencer supplies one operation code for the address register and one for the program counter. The block picks each register's next value from the instruction word, the memory buffer, the memory data word, the switch register, two stack pointers, a set of constants, incremented copies of these, or the page-relative target of a memory-reference instruction.

A page-relative target joins a 5-bit page number with the 7-bit word offset held in the low bits of the instruction word. The page number is either forced to zero or copied from the current address register. The sequencer decides whether a reference is indirect. It passes only the page-select bit of the 2-bit addressing mode, whose encoding is 00 direct zero page, 01 direct current page, 10 indirect zero page and 11 indirect current page.

Top module: `mem_addr_next`

## Requirements
- R1: While `rst_n` is low, both `ma` and `pc` read 0000 octal. Reset is asynchronous and active low.
- R2: Operation code 0 on `ma_op` leaves `ma` unchanged, and code 0 on `pc_op` leaves `pc` unchanged, whatever the operand inputs do.
- R3: The zero-page target is five zero bits followed by `ir[6:0]`. It is loaded by `ma_op` 3 and `pc_op` 12.
- R4: The current-page target is `ma[11:7]`, taken as it stands before the edge, followed by `ir[6:0]`. It is loaded by `ma_op` 4 and `pc_op` 13.
- R5: `ma_op` 16 and `pc_op` 16 load the mode-selected target. When `cur_pg` is 0 this is the zero-page target, and when `cur_pg` is 1 it is the current-page target.
- R6: `pc_op` 14, 15 and 17 load the zero-page, current-page and mode-selected targets plus one. The carry may move the result into the next page.
- R7: `ma_op` loads the following values. 1 gives 0000. 2 gives ma+1. 5 gives ir. 6 gives pc. 7 gives pc+1. 8 gives mb. 9 gives md. 10 gives md+1. 11 gives sp_a. 12 gives sp_a+1. 13 gives sp_b. 14 gives sp_b+1. 15 gives sw.
- R8: `pc_op` 1, 2 and 3 preset `pc` to 0000, 0001 and 7777 octal.
- R9: `pc_op` loads the following values. 4 gives pc+1. 5 gives ma. 6 gives ma+1. 7 gives mb. 8 gives mb+1. 9 gives md. 10 gives md+1. 11 gives sw.
- R10: Every increment wraps modulo 4096, so 7777 octal plus one gives 0000.
- R11: Both registers update on the same edge from pre-edge values. With `ma_op` 6 and `pc_op` 5 together, the two registers swap.
- R12: Unassigned codes (`ma_op` 17 to 31, `pc_op` 18 to 31) hold the register, as code 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ma_op | input | 5 | Address register operation code |
| pc_op | input | 5 | Program counter operation code |
| cur_pg | input | 1 | Page-select bit of the addressing mode (1 = current page) |
| ir | input | 12 | Instruction word; bits 6:0 are the in-page offset |
| mb | input | 12 | Memory buffer operand |
| md | input | 12 | Memory data operand |
| sp_a | input | 12 | First stack pointer operand |
| sp_b | input | 12 | Second stack pointer operand |
| sw | input | 12 | Switch register operand |
| ma | output | 12 | Memory address register |
| pc | output | 12 | Program counter |

## Verification
Both registers drive the outputs directly, so a wrong selection or a bad increment shows up on `ma` or `pc` one edge after the code that caused it. A fault that does not touch the selected source can stay hidden until an operation reads the corrupted register. This applies to a current-page target formed from the wrong page bits, and to a register altered on a hold code. For that reason, each load is followed by operations that read the result back: page targets after an address load, and a swap that exposes any mix-up between old and new values. The page-crossing and 7777-to-0000 corners are driven on purpose, because a dropped carry changes only the high bits.

// File: rtl/mem_addr_pkg.sv
package mem_addr_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      MA_HOLD  = 5'd0,
      MA_ZERO  = 5'd1,
      MA_INC   = 5'd2,
      MA_ZPG   = 5'd3,
      MA_CPG   = 5'd4,
      MA_IR    = 5'd5,
      MA_PC    = 5'd6,
      MA_PC1   = 5'd7,
      MA_MB    = 5'd8,
      MA_MD    = 5'd9,
      MA_MD1   = 5'd10,
      MA_SPA   = 5'd11,
      MA_SPA1  = 5'd12,
      MA_SPB   = 5'd13,
      MA_SPB1  = 5'd14,
      MA_SW    = 5'd15,
      MA_EFF   = 5'd16
   } ma_op_e;

   typedef enum logic [OP_W-1:0] {
      PC_HOLD  = 5'd0,
      PC_ZERO  = 5'd1,
      PC_ONE   = 5'd2,
      PC_ONES  = 5'd3,
      PC_INC   = 5'd4,
      PC_MA    = 5'd5,
      PC_MA1   = 5'd6,
      PC_MB    = 5'd7,
      PC_MB1   = 5'd8,
      PC_MD    = 5'd9,
      PC_MD1   = 5'd10,
      PC_SW    = 5'd11,
      PC_ZPG   = 5'd12,
      PC_CPG   = 5'd13,
      PC_ZPG1  = 5'd14,
      PC_CPG1  = 5'd15,
      PC_EFF   = 5'd16,
      PC_EFF1  = 5'd17
   } pc_op_e;

   // operand slots fed through the shared incrementer bank
   localparam int SRC_MA  = 0;
   localparam int SRC_PC  = 1;
   localparam int SRC_MB  = 2;
   localparam int SRC_MD  = 3;
   localparam int SRC_SPA = 4;
   localparam int SRC_SPB = 5;
   localparam int N_SRC   = 6;

endpackage

// File: rtl/mem_addr_inc.sv
module mem_addr_inc #(
   parameter int W      = 12,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);

   generate
      if (W < 2) begin : g_bad_w
         $error("mem_addr_inc: W must be at least 2");
      end
      if (RIPPLE) begin : g_ripple
         // explicit half-adder chain, carry out of the top bit dropped
         logic [W-1:0] cy;
         assign cy[0] = 1'b1;
         for (genvar i = 0; i < W; i++) begin : g_sum
            assign y[i] = a[i] ^ cy[i];
         end
         for (genvar i = 0; i < W - 1; i++) begin : g_cy
            assign cy[i+1] = a[i] & cy[i];
         end
      end else begin : g_adder
         assign y = a + {{(W-1){1'b0}}, 1'b1};
      end
   endgenerate

endmodule

// File: rtl/mem_addr_tgt.sv
module mem_addr_tgt #(
   parameter int AW     = 12,
   parameter int OW     = 7,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [AW-1:0]    ma_cur,
   input  logic [OW-1:0]    ofs,
   input  logic             cur_pg,
   output logic [AW-1:0]    zp,
   output logic [AW-1:0]    cp,
   output logic [AW-1:0]    eff,
   output logic [AW-1:0]    zp1,
   output logic [AW-1:0]    cp1,
   output logic [AW-1:0]    eff1
);

   localparam int PW = AW - OW;

   assign zp  = {{PW{1'b0}}, ofs};
   assign cp  = {ma_cur[AW-1:OW], ofs};
   assign eff = cur_pg ? cp : zp;

   mem_addr_inc #(.W(AW), .RIPPLE(RIPPLE)) u_inc_zp  (.a(zp),  .y(zp1));
   mem_addr_inc #(.W(AW), .RIPPLE(RIPPLE)) u_inc_cp  (.a(cp),  .y(cp1));
   mem_addr_inc #(.W(AW), .RIPPLE(RIPPLE)) u_inc_eff (.a(eff), .y(eff1));

endmodule

// File: rtl/mem_addr_ma_mux.sv
module mem_addr_ma_mux
   import mem_addr_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic [OP_W-1:0]         op,
   input  logic [N_SRC-1:0][AW-1:0] src,
   input  logic [N_SRC-1:0][AW-1:0] src_inc,
   input  logic [AW-1:0]            ir,
   input  logic [AW-1:0]            sw,
   input  logic [AW-1:0]            zp,
   input  logic [AW-1:0]            cp,
   input  logic [AW-1:0]            eff,
   output logic [AW-1:0]            nxt
);

   ma_op_e sel;
   assign sel = ma_op_e'(op);

   always_comb begin
      nxt = src[SRC_MA];
      case (sel)
         MA_ZERO : nxt = '0;
         MA_INC  : nxt = src_inc[SRC_MA];
         MA_ZPG  : nxt = zp;
         MA_CPG  : nxt = cp;
         MA_IR   : nxt = ir;
         MA_PC   : nxt = src[SRC_PC];
         MA_PC1  : nxt = src_inc[SRC_PC];
         MA_MB   : nxt = src[SRC_MB];
         MA_MD   : nxt = src[SRC_MD];
         MA_MD1  : nxt = src_inc[SRC_MD];
         MA_SPA  : nxt = src[SRC_SPA];
         MA_SPA1 : nxt = src_inc[SRC_SPA];
         MA_SPB  : nxt = src[SRC_SPB];
         MA_SPB1 : nxt = src_inc[SRC_SPB];
         MA_SW   : nxt = sw;
         MA_EFF  : nxt = eff;
         default : nxt = src[SRC_MA];
      endcase
   end

endmodule

// File: rtl/mem_addr_pc_mux.sv
module mem_addr_pc_mux
   import mem_addr_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic [OP_W-1:0]          op,
   input  logic [N_SRC-1:0][AW-1:0] src,
   input  logic [N_SRC-1:0][AW-1:0] src_inc,
   input  logic [AW-1:0]            sw,
   input  logic [AW-1:0]            zp,
   input  logic [AW-1:0]            cp,
   input  logic [AW-1:0]            eff,
   input  logic [AW-1:0]            zp1,
   input  logic [AW-1:0]            cp1,
   input  logic [AW-1:0]            eff1,
   output logic [AW-1:0]            nxt
);

   localparam logic [AW-1:0] K_ONE = {{(AW-1){1'b0}}, 1'b1};

   pc_op_e sel;
   assign sel = pc_op_e'(op);

   always_comb begin
      nxt = src[SRC_PC];
      case (sel)
         PC_ZERO : nxt = '0;
         PC_ONE  : nxt = K_ONE;
         PC_ONES : nxt = '1;
         PC_INC  : nxt = src_inc[SRC_PC];
         PC_MA   : nxt = src[SRC_MA];
         PC_MA1  : nxt = src_inc[SRC_MA];
         PC_MB   : nxt = src[SRC_MB];
         PC_MB1  : nxt = src_inc[SRC_MB];
         PC_MD   : nxt = src[SRC_MD];
         PC_MD1  : nxt = src_inc[SRC_MD];
         PC_SW   : nxt = sw;
         PC_ZPG  : nxt = zp;
         PC_CPG  : nxt = cp;
         PC_ZPG1 : nxt = zp1;
         PC_CPG1 : nxt = cp1;
         PC_EFF  : nxt = eff;
         PC_EFF1 : nxt = eff1;
         default : nxt = src[SRC_PC];
      endcase
   end

endmodule

// File: rtl/mem_addr_next.sv
module mem_addr_next
   import mem_addr_pkg::*;
#(
   parameter int AW     = 12,
   parameter int OW     = 7,
   parameter bit RIPPLE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [4:0]      ma_op,
   input  logic [4:0]      pc_op,
   input  logic            cur_pg,
   input  logic [AW-1:0]   ir,
   input  logic [AW-1:0]   mb,
   input  logic [AW-1:0]   md,
   input  logic [AW-1:0]   sp_a,
   input  logic [AW-1:0]   sp_b,
   input  logic [AW-1:0]   sw,
   output logic [AW-1:0]   ma,
   output logic [AW-1:0]   pc
);

   localparam int PW = AW - OW;

   generate
      if (OW < 1) begin : g_bad_ow
         $error("mem_addr_next: offset width must be positive");
      end
      if (PW < 1) begin : g_bad_pw
         $error("mem_addr_next: address must be wider than the offset");
      end
      if (OP_W != 5) begin : g_bad_op
         $error("mem_addr_next: operation code ports are 5 bits");
      end
   endgenerate

   logic [AW-1:0] ma_q, pc_q, ma_d, pc_d;
   logic [N_SRC-1:0][AW-1:0] src, src_inc;
   logic [AW-1:0] zp, cp, eff, zp1, cp1, eff1;

   assign src[SRC_MA]  = ma_q;
   assign src[SRC_PC]  = pc_q;
   assign src[SRC_MB]  = mb;
   assign src[SRC_MD]  = md;
   assign src[SRC_SPA] = sp_a;
   assign src[SRC_SPB] = sp_b;

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_inc
         mem_addr_inc #(.W(AW), .RIPPLE(RIPPLE)) u_inc (
            .a (src[s]),
            .y (src_inc[s])
         );
      end
   endgenerate

   mem_addr_tgt #(.AW(AW), .OW(OW), .RIPPLE(RIPPLE)) u_tgt (
      .ma_cur (ma_q),
      .ofs    (ir[OW-1:0]),
      .cur_pg (cur_pg),
      .zp     (zp),
      .cp     (cp),
      .eff    (eff),
      .zp1    (zp1),
      .cp1    (cp1),
      .eff1   (eff1)
   );

   mem_addr_ma_mux #(.AW(AW)) u_ma_mux (
      .op      (ma_op),
      .src     (src),
      .src_inc (src_inc),
      .ir      (ir),
      .sw      (sw),
      .zp      (zp),
      .cp      (cp),
      .eff     (eff),
      .nxt     (ma_d)
   );

   mem_addr_pc_mux #(.AW(AW)) u_pc_mux (
      .op      (pc_op),
      .src     (src),
      .src_inc (src_inc),
      .sw      (sw),
      .zp      (zp),
      .cp      (cp),
      .eff     (eff),
      .zp1     (zp1),
      .cp1     (cp1),
      .eff1    (eff1),
      .nxt     (pc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma_q <= '0;
         pc_q <= '0;
      end else begin
         ma_q <= ma_d;
         pc_q <= pc_d;
      end
   end

   assign ma = ma_q;
   assign pc = pc_q;

endmodule

// File: rtl/mem_addr_next_chk.sv
module mem_addr_next_chk #(
   parameter int AW = 12,
   parameter int OW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    ma_op,
   input logic [4:0]    pc_op,
   input logic [AW-1:0] ir,
   input logic [AW-1:0] ma,
   input logic [AW-1:0] pc
);

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (ma == '0 && pc == '0));

   // R2
   ma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ma_op == 5'd0 |=> ma == $past(ma));

   // R2
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_op == 5'd0 |=> pc == $past(pc));

   // R3
   zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ma_op == 5'd3 |=> (ma[AW-1:OW] == '0 && ma[OW-1:0] == $past(ir[OW-1:0])));

   // R4
   cur_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_op == 5'd13 |=> pc == {$past(ma[AW-1:OW]), $past(ir[OW-1:0])});

   // R8
   preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_op == 5'd3 |=> pc == '1);

   // R11
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ma_op == 5'd6 && pc_op == 5'd5) |=> (ma == $past(pc) && pc == $past(ma)));

   // R12
   ma_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ma_op > 5'd16 |=> $stable(ma));

endmodule

bind mem_addr_next mem_addr_next_chk #(.AW(AW), .OW(OW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ma_op (ma_op),
   .pc_op (pc_op),
   .ir    (ir),
   .ma    (ma),
   .pc    (pc)
);

// File: tb/mem_addr_next_tb.sv
module mem_addr_next_tb;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  ma_op = '0, pc_op = '0;
   logic        cur_pg = 1'b0;
   logic [11:0] ir = '0, mb = '0, md = '0, sp_a = '0, sp_b = '0, sw = '0;
   logic [11:0] ma, pc;

   int n_chk = 0;
   int n_err = 0;

   always #(PERIOD/2) clk = ~clk;

   mem_addr_next u_dut (
      .clk(clk), .rst_n(rst_n), .ma_op(ma_op), .pc_op(pc_op), .cur_pg(cur_pg),
      .ir(ir), .mb(mb), .md(md), .sp_a(sp_a), .sp_b(sp_b), .sw(sw),
      .ma(ma), .pc(pc)
   );

   task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %o expected %o", tag, got, exp);
      end
   endtask

   task automatic step(input logic [4:0] mop, input logic [4:0] pop);
      @(negedge clk);
      ma_op = mop;
      pc_op = pop;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 ma in reset", ma, 12'o0000);
      chk("R1 pc in reset", pc, 12'o0000);
      @(negedge clk);
      rst_n = 1'b1;
      step(5'd0, 5'd0);
      chk("R2 ma after release", ma, 12'o0000);
   endtask

   task automatic t_ma_loads;
      ir = 12'o1234; mb = 12'o2345; md = 12'o3456;
      sp_a = 12'o4567; sp_b = 12'o5670; sw = 12'o6701;
      step(5'd5, 5'd0);  chk("R7 ma<-ir", ma, 12'o1234);
      chk("R2 pc held", pc, 12'o0000);
      step(5'd8, 5'd0);  chk("R7 ma<-mb", ma, 12'o2345);
      step(5'd9, 5'd0);  chk("R7 ma<-md", ma, 12'o3456);
      step(5'd10, 5'd0); chk("R7 ma<-md+1", ma, 12'o3457);
      step(5'd11, 5'd0); chk("R7 ma<-sp_a", ma, 12'o4567);
      step(5'd12, 5'd0); chk("R7 ma<-sp_a+1", ma, 12'o4570);
      step(5'd13, 5'd0); chk("R7 ma<-sp_b", ma, 12'o5670);
      step(5'd14, 5'd0); chk("R7 ma<-sp_b+1", ma, 12'o5671);
      step(5'd15, 5'd0); chk("R7 ma<-sw", ma, 12'o6701);
      step(5'd2, 5'd0);  chk("R7 ma<-ma+1", ma, 12'o6702);
      step(5'd1, 5'd0);  chk("R7 ma<-0", ma, 12'o0000);
      step(5'd0, 5'd11); chk("R9 pc<-sw", pc, 12'o6701);
      step(5'd7, 5'd0);  chk("R7 ma<-pc+1", ma, 12'o6702);
      step(5'd6, 5'd0);  chk("R7 ma<-pc", ma, 12'o6701);
   endtask

   task automatic t_pc_loads;
      step(5'd0, 5'd3);  chk("R8 pc<-7777", pc, 12'o7777);
      step(5'd0, 5'd4);  chk("R10 pc+1 wraps", pc, 12'o0000);
      step(5'd0, 5'd2);  chk("R8 pc<-0001", pc, 12'o0001);
      step(5'd0, 5'd1);  chk("R8 pc<-0000", pc, 12'o0000);
      step(5'd0, 5'd11); chk("R9 pc<-sw", pc, 12'o6701);
      step(5'd0, 5'd4);  chk("R9 pc<-pc+1", pc, 12'o6702);
      step(5'd0, 5'd7);  chk("R9 pc<-mb", pc, 12'o2345);
      step(5'd0, 5'd8);  chk("R9 pc<-mb+1", pc, 12'o2346);
      step(5'd0, 5'd9);  chk("R9 pc<-md", pc, 12'o3456);
      step(5'd0, 5'd10); chk("R9 pc<-md+1", pc, 12'o3457);
      sw = 12'o4321;
      step(5'd15, 5'd0);
      step(5'd0, 5'd5);  chk("R9 pc<-ma", pc, 12'o4321);
      step(5'd0, 5'd6);  chk("R9 pc<-ma+1", pc, 12'o4322);
   endtask

   task automatic t_pages;
      sw = 12'o5432; ir = 12'o0377;
      step(5'd15, 5'd0);
      step(5'd0, 5'd12); chk("R3 pc zero page", pc, 12'o0177);
      step(5'd0, 5'd13); chk("R4 pc current page", pc, 12'o5577);
      step(5'd0, 5'd14); chk("R6 pc zero page+1", pc, 12'o0200);
      step(5'd0, 5'd15); chk("R6 pc current page+1 crosses page", pc, 12'o5600);
      step(5'd4, 5'd0);  chk("R4 ma current page", ma, 12'o5577);
      step(5'd3, 5'd0);  chk("R3 ma zero page", ma, 12'o0177);
   endtask

   task automatic t_mode;
      sw = 12'o5432; ir = 12'o0377;
      step(5'd15, 5'd0);
      cur_pg = 1'b0;
      step(5'd0, 5'd16); chk("R5 mode zero page", pc, 12'o0177);
      cur_pg = 1'b1;
      step(5'd0, 5'd16); chk("R5 mode current page", pc, 12'o5577);
      step(5'd0, 5'd17); chk("R6 mode target+1", pc, 12'o5600);
      cur_pg = 1'b0;
      step(5'd0, 5'd17); chk("R6 mode zero target+1", pc, 12'o0200);
      cur_pg = 1'b1;
      step(5'd16, 5'd0); chk("R5 ma mode current page", ma, 12'o5577);
   endtask

   task automatic t_swap;
      sw = 12'o1000; step(5'd15, 5'd0);
      sw = 12'o2000; step(5'd0, 5'd11);
      step(5'd6, 5'd5);
      chk("R11 ma took old pc", ma, 12'o2000);
      chk("R11 pc took old ma", pc, 12'o1000);
   endtask

   task automatic t_hold;
      ir = 12'o7070; mb = 12'o0707; md = 12'o1111; sw = 12'o2222;
      sp_a = 12'o3333; sp_b = 12'o4444; cur_pg = 1'b0;
      step(5'd0, 5'd0);
      chk("R2 ma hold", ma, 12'o2000);
      chk("R2 pc hold", pc, 12'o1000);
      step(5'd20, 5'd25);
      chk("R12 ma unused code", ma, 12'o2000);
      chk("R12 pc unused code", pc, 12'o1000);
      step(5'd31, 5'd18);
      chk("R12 ma code 31", ma, 12'o2000);
      chk("R12 pc code 18", pc, 12'o1000);
   endtask

   task automatic t_wrap;
      sw = 12'o7777; md = 12'o7777; mb = 12'o7777; sp_a = 12'o7777;
      step(5'd15, 5'd10);
      chk("R10 pc<-md+1 wraps", pc, 12'o0000);
      step(5'd2, 5'd6);
      chk("R10 ma+1 wraps", ma, 12'o0000);
      chk("R10 pc<-ma+1 wraps", pc, 12'o0000);
      step(5'd12, 5'd8);
      chk("R10 sp_a+1 wraps", ma, 12'o0000);
      chk("R10 pc<-mb+1 wraps", pc, 12'o0000);
   endtask

   task automatic t_mid_reset;
      sw = 12'o3210;
      step(5'd15, 5'd11);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 ma async clear", ma, 12'o0000);
      chk("R1 pc async clear", pc, 12'o0000);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(PERIOD * 20000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_ma_loads();
      t_pc_loads();
      t_pages();
      t_mode();
      t_swap();
      t_hold();
      t_wrap();
      t_mid_reset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule